// File: doc/BRIEF.md
# Handshake-Paced Byte Shifter

This block moves whole bytes between a host processor and a small peripheral controller through one 8-bit shift-data register. The host does not clock individual bits. Instead it flips either of two active-low handshake lines in a port register. Every change of that pair moves exactly one byte. A direction bit in an auxiliary control register selects the way the byte travels.

In the inbound direction, each move loads the next queued reply byte into the shift-data register. A transfer-request line stays low while reply bytes are still unread. In the outbound direction, each move copies the shift-data register into a capture buffer. When the direction bit falls, the captured bytes form a finished packet. The block announces the packet with a one-cycle pulse and then streams it out.

Replies enter on a valid/ready stream. Its ready is high only while the previous reply has been fully read. Packets leave on a valid/ready stream. That stream keeps each byte stable until the consumer takes it. A shift flag records each byte move, and an interrupt line reports the flag when it is enabled.

Top module: `hsk_byte_shifter`

## Requirements
- R1: After reset, port register bit 3 reads 1, the flag register reads 0, `irq`, `pkt_valid` and `pkt_done` are 0, `treq_n` is 1 and `rpl_ready` is 1.
- R2: Host register addresses:
  - 0 is the port register, with bit 4 acknowledge, bit 5 in-progress and bit 3 transfer request (read-only).
  - 1 is shift data.
  - 2 is auxiliary control, with bit 4 as direction (1 = host to device).
  - 3 is flags, with bit 2 the shift flag and bit 7 the `irq` state.
  - 4 is the enable register. A write with bit 7 = 1 sets the enable bits given in bits 6:0, a write with bit 7 = 0 clears them, and a read returns {0, enables}.
- R3: With direction 0, each change of the port bit 5/bit 4 pair loads the next unread reply byte into shift data one clock after the port write. The bytes come in the order they were streamed in.
- R4: `treq_n` (also port bit 3 on read) is 0 while unread reply bytes remain and 1 once they are exhausted. Further pair changes then leave shift data unchanged and do not set the flag.
- R5: `rpl_ready` is 1 only when the reply is exhausted. The bytes of a reply are taken in order up to `rpl_last`. At most 128 are kept and any excess is discarded. The read position restarts at the first byte.
- R6: With direction 1, each pair change copies shift data into the capture buffer, which holds at most 16 bytes. Changes beyond that are dropped and do not set the flag. Shift data is not altered by a capture.
- R7: A 1-to-0 change of the direction bit with at least one captured byte gives a one-cycle `pkt_done` pulse. The captured bytes then appear in order on the packet stream, with `pkt_last` on the final one, and the capture count returns to zero. A fall with nothing captured gives neither a pulse nor a stream.
- R8: While `pkt_valid` is 1 and `pkt_ready` is 0, valid, data and last hold steady. Pair changes made while a packet is still streaming are dropped.
- R9: The shift flag is set by every byte move in either direction. It is cleared by a host read of shift data. A move in the same cycle as such a read wins.
- R10: `irq` is 1 exactly when the shift flag and enable bit 2 are both 1.
- R11: A port register write that changes neither bit 4 nor bit 5 moves no byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe (side effects only) |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational on address) |
| rpl_valid | input | 1 | Reply byte valid |
| rpl_ready | output | 1 | Reply byte accepted |
| rpl_data | input | 8 | Reply byte |
| rpl_last | input | 1 | Final byte of a reply |
| pkt_valid | output | 1 | Packet byte valid |
| pkt_ready | input | 1 | Packet consumer ready |
| pkt_data | output | 8 | Packet byte |
| pkt_last | output | 1 | Final byte of a packet |
| pkt_done | output | 1 | One-cycle packet completion pulse |
| treq_n | output | 1 | Active-low transfer request |
| irq | output | 1 | Shift interrupt |

## Verification
The bench sweeps reply lengths up to and past the 128-byte limit and keeps toggling after exhaustion. A design that lost the bound would load stale bytes or keep `treq_n` low. Outbound packets of 1, 3, 16 and 19 bytes catch a capture buffer that wraps and overwrites its first entries, or one that raises the flag on dropped bytes. It also checks that closing an empty packet gives no pulse, and that toggles made while a packet is stalled are dropped. A design that corrupted the stalled stream or counted a phantom byte would fail there. Toggling the two handshake bits alternately, and writing a port change that leaves both alone, exposes a detector that watches only one bit or reacts to any port write.

// File: rtl/hsk_pkg.sv
package hsk_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    RA_PORT   = 3'd0,
    RA_SHIFT  = 3'd1,
    RA_AUX    = 3'd2,
    RA_FLAG   = 3'd3,
    RA_ENABLE = 3'd4
  } reg_addr_e;

  localparam int PB_REQ_BIT    = 3;
  localparam int PB_ACK_BIT    = 4;
  localparam int PB_TIP_BIT    = 5;
  localparam int AUX_DIR_BIT   = 4;
  localparam int FLG_SHIFT_BIT = 2;
  localparam int FLG_ANY_BIT   = 7;
  localparam int EN_SETCLR_BIT = 7;
  localparam int EN_W          = 7;
endpackage

// File: rtl/hsk_host_regs.sv
module hsk_host_regs
  import hsk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [2:0]      addr,
  input  byte_t           wdata,
  output byte_t           port_q,
  output byte_t           aux_q,
  output logic [EN_W-1:0] en_q,
  output logic            hs_change,
  output logic            dir_out,
  output logic            dir_fall
);
  logic [1:0] hs_now;
  logic [1:0] hs_prev;
  logic       dir_prev;

  assign hs_now    = {port_q[PB_TIP_BIT], port_q[PB_ACK_BIT]};
  assign hs_change = (hs_now != hs_prev);
  assign dir_out   = aux_q[AUX_DIR_BIT];
  assign dir_fall  = dir_prev & ~dir_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q   <= '1;
      aux_q    <= '0;
      en_q     <= '0;
      hs_prev  <= 2'b11;
      dir_prev <= 1'b0;
    end else begin
      if (we) begin
        case (reg_addr_e'(addr))
          RA_PORT: port_q <= wdata;
          RA_AUX:  aux_q  <= wdata;
          RA_ENABLE: begin
            if (wdata[EN_SETCLR_BIT]) en_q <= en_q | wdata[EN_W-1:0];
            else                      en_q <= en_q & ~wdata[EN_W-1:0];
          end
          default: ;
        endcase
      end
      hs_prev  <= hs_now;
      dir_prev <= dir_out;
    end
  end
endmodule

// File: rtl/hsk_reply_buf.sv
module hsk_reply_buf
  import hsk_pkg::*;
#(
  parameter int DEPTH = 128
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  byte_t in_data,
  input  logic  in_last,
  input  logic  take,
  output logic  avail,
  output byte_t head
);
  localparam int AW = $clog2(DEPTH);
  localparam int IW = $clog2(DEPTH + 1);

  byte_t         mem [DEPTH];
  logic [IW-1:0] rd_idx;
  logic [IW-1:0] len_q;
  logic [IW-1:0] wr_cnt;
  logic          accept;
  logic          keep;

  assign avail    = (rd_idx < len_q);
  assign in_ready = ~avail;
  assign head     = mem[rd_idx[AW-1:0]];
  assign accept   = in_valid & in_ready;
  assign keep     = accept & (wr_cnt < IW'(DEPTH));

  always_ff @(posedge clk) begin
    if (keep) mem[wr_cnt[AW-1:0]] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_idx <= '0;
      len_q  <= '0;
      wr_cnt <= '0;
    end else if (accept) begin
      if (in_last) begin
        len_q  <= keep ? wr_cnt + IW'(1) : wr_cnt;
        rd_idx <= '0;
        wr_cnt <= '0;
      end else if (keep) begin
        wr_cnt <= wr_cnt + IW'(1);
      end
    end else if (take && avail) begin
      rd_idx <= rd_idx + IW'(1);
    end
  end
endmodule

// File: rtl/hsk_capture_buf.sv
module hsk_capture_buf
  import hsk_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  cap,
  input  byte_t cap_data,
  input  logic  close,
  output logic  stored,
  output logic  done,
  output logic  out_valid,
  input  logic  out_ready,
  output byte_t out_data,
  output logic  out_last
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  byte_t         mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] dlen;
  logic [AW-1:0] didx;
  logic          draining;

  assign stored    = cap & ~draining & (cnt < CW'(DEPTH));
  assign done      = close & (cnt != '0);
  assign out_valid = draining;
  assign out_data  = mem[didx];
  assign out_last  = (CW'(didx) + CW'(1)) == dlen;

  always_ff @(posedge clk) begin
    if (stored) mem[cnt[AW-1:0]] <= cap_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      dlen     <= '0;
      didx     <= '0;
      draining <= 1'b0;
    end else begin
      if (close)       cnt <= '0;
      else if (stored) cnt <= cnt + CW'(1);

      if (done) begin
        draining <= 1'b1;
        dlen     <= cnt;
        didx     <= '0;
      end else if (out_valid && out_ready) begin
        if (out_last) draining <= 1'b0;
        else          didx     <= didx + AW'(1);
      end
    end
  end
endmodule

// File: rtl/hsk_byte_shifter.sv
module hsk_byte_shifter
  import hsk_pkg::*;
#(
  parameter int REPLY_DEPTH = 128,
  parameter int CAPT_DEPTH  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic       host_re,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       rpl_valid,
  output logic       rpl_ready,
  input  logic [7:0] rpl_data,
  input  logic       rpl_last,
  output logic       pkt_valid,
  input  logic       pkt_ready,
  output logic [7:0] pkt_data,
  output logic       pkt_last,
  output logic       pkt_done,
  output logic       treq_n,
  output logic       irq
);
  byte_t           port_q;
  byte_t           aux_q;
  logic [EN_W-1:0] en_q;
  logic            hs_change;
  logic            dir_out;
  logic            dir_fall;
  logic            avail;
  byte_t           head;
  logic            move_in;
  logic            cap;
  logic            stored;
  byte_t           sr_q;
  logic            flag_q;
  logic            sr_read;

  hsk_host_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(host_we), .addr(host_addr),
    .wdata(host_wdata), .port_q(port_q), .aux_q(aux_q), .en_q(en_q),
    .hs_change(hs_change), .dir_out(dir_out), .dir_fall(dir_fall)
  );

  hsk_reply_buf #(.DEPTH(REPLY_DEPTH)) u_reply (
    .clk(clk), .rst_n(rst_n), .in_valid(rpl_valid), .in_ready(rpl_ready),
    .in_data(rpl_data), .in_last(rpl_last), .take(move_in),
    .avail(avail), .head(head)
  );

  hsk_capture_buf #(.DEPTH(CAPT_DEPTH)) u_capt (
    .clk(clk), .rst_n(rst_n), .cap(cap), .cap_data(sr_q), .close(dir_fall),
    .stored(stored), .done(pkt_done), .out_valid(pkt_valid),
    .out_ready(pkt_ready), .out_data(pkt_data), .out_last(pkt_last)
  );

  assign move_in = hs_change & ~dir_out & avail;
  assign cap     = hs_change & dir_out;
  assign treq_n  = ~avail;
  assign sr_read = host_re & (host_addr == RA_SHIFT);
  assign irq     = flag_q & en_q[FLG_SHIFT_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      if (move_in)                                   sr_q <= head;
      else if (host_we && host_addr == RA_SHIFT)     sr_q <= host_wdata;

      if (move_in || stored) flag_q <= 1'b1;
      else if (sr_read)      flag_q <= 1'b0;
    end
  end

  always_comb begin
    host_rdata = '0;
    case (reg_addr_e'(host_addr))
      RA_PORT: begin
        host_rdata             = port_q;
        host_rdata[PB_REQ_BIT] = treq_n;
      end
      RA_SHIFT: host_rdata = sr_q;
      RA_AUX:   host_rdata = aux_q;
      RA_FLAG: begin
        host_rdata[FLG_SHIFT_BIT] = flag_q;
        host_rdata[FLG_ANY_BIT]   = irq;
      end
      RA_ENABLE: host_rdata = {1'b0, en_q};
      default:   host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/hsk_checker.sv
module hsk_checker
  import hsk_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            host_we,
  input logic [2:0]      host_addr,
  input logic            hs_change,
  input logic            dir_out,
  input logic [EN_W-1:0] en_q,
  input logic            flag_q,
  input byte_t           sr_q,
  input logic            treq_n,
  input logic            rpl_valid,
  input logic            rpl_ready,
  input logic            pkt_valid,
  input logic            pkt_ready,
  input byte_t           pkt_data,
  input logic            pkt_last,
  input logic            pkt_done,
  input logic            irq
);
  AST_SR_MOVES_ON_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q != $past(sr_q)) |-> $past(hs_change || (host_we && host_addr == RA_SHIFT))); // R3

  AST_TREQ_RISE_AFTER_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(treq_n) |-> $past(hs_change && !dir_out)); // R4

  AST_RPL_ONLY_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rpl_valid && rpl_ready) |-> treq_n); // R5

  AST_DONE_THEN_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> pkt_valid); // R7

  AST_PKT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !pkt_ready) |=> (pkt_valid && $stable(pkt_data) && $stable(pkt_last))); // R8

  AST_FLAG_SET_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(hs_change)); // R9

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != $past(irq)) |-> ((flag_q != $past(flag_q)) || (en_q[FLG_SHIFT_BIT] != $past(en_q[FLG_SHIFT_BIT])))); // R10
endmodule

bind hsk_byte_shifter hsk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
  .hs_change(hs_change), .dir_out(dir_out), .en_q(en_q), .flag_q(flag_q),
  .sr_q(sr_q), .treq_n(treq_n), .rpl_valid(rpl_valid), .rpl_ready(rpl_ready),
  .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
  .pkt_last(pkt_last), .pkt_done(pkt_done), .irq(irq)
);

// File: tb/tb_hsk_byte_shifter.sv
module tb_hsk_byte_shifter;
  import hsk_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_we = 1'b0, host_re = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       rpl_valid = 1'b0, rpl_last = 1'b0;
  logic [7:0] rpl_data = '0;
  logic       rpl_ready;
  logic       pkt_valid, pkt_last, pkt_done, treq_n, irq;
  logic [7:0] pkt_data;
  logic       pkt_ready = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] pb_sh = 8'hFF;
  bit finished = 0;

  always #2 clk = ~clk;

  hsk_byte_shifter dut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_re(host_re),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .rpl_valid(rpl_valid), .rpl_ready(rpl_ready), .rpl_data(rpl_data),
    .rpl_last(rpl_last), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data), .pkt_last(pkt_last), .pkt_done(pkt_done),
    .treq_n(treq_n), .irq(irq)
  );

  function automatic logic [7:0] rbyte(int i, int n);
    return 8'((i * 37 + n * 5 + 1) & 255);
  endfunction

  function automatic logic [7:0] obyte(int i, int n);
    return 8'((i * 11 + n * 29 + 3) & 255);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_re = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_re = 1'b0;
  endtask

  task automatic toggle(input int which);
    if (which % 2 == 0) pb_sh[PB_TIP_BIT] = ~pb_sh[PB_TIP_BIT];
    else                pb_sh[PB_ACK_BIT] = ~pb_sh[PB_ACK_BIT];
    wr(RA_PORT, pb_sh);
    @(negedge clk);
  endtask

  task automatic load_reply(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rpl_valid = 1'b1; rpl_data = rbyte(i, n); rpl_last = (i == n - 1);
      @(posedge clk);
    end
    @(negedge clk);
    rpl_valid = 1'b0; rpl_last = 1'b0;
  endtask

  task automatic drain(int n_exp, int n_pk);
    int got = 0;
    bit hold = 0;
    bit fin = 0;
    logic [7:0] pd = '0;
    for (int c = 0; c < 400 && !fin; c++) begin
      @(negedge clk);
      if (hold) check("R8 held data", pkt_data, pd);
      pkt_ready = (c % 3) != 1;
      if (pkt_valid && pkt_ready) begin
        check("R7 packet byte", pkt_data, obyte(got, n_pk));
        check("R7 packet last", pkt_last, (got == n_exp - 1));
        got++;
        if (pkt_last) fin = 1;
      end
      hold = pkt_valid && !pkt_ready;
      pd   = pkt_data;
    end
    check("R7 packet length", got, n_exp);
    @(negedge clk);
    pkt_ready = 1'b0;
    check("R7 stream idle after packet", pkt_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d;
    int k;
    int lens[5] = '{1, 2, 5, 128, 131};
    int olen[4] = '{1, 3, 16, 19};
    logic [7:0] last_sr;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(RA_PORT, d); check("R1 port bit3", d[PB_REQ_BIT], 1);
    rd(RA_FLAG, d); check("R1 flags", d, 0);
    check("R1 irq", irq, 0);
    check("R1 pkt_valid", pkt_valid, 0);
    check("R1 pkt_done", pkt_done, 0);
    check("R1 treq_n", treq_n, 1);
    check("R1 rpl_ready", rpl_ready, 1);

    // R2 register map
    wr(RA_ENABLE, 8'h85); rd(RA_ENABLE, d); check("R2 enable set", d, 8'h05);
    wr(RA_ENABLE, 8'h01); rd(RA_ENABLE, d); check("R2 enable clear", d, 8'h04);
    wr(RA_AUX, 8'h10);    rd(RA_AUX, d);    check("R2 aux", d, 8'h10);
    wr(RA_AUX, 8'h00);
    check("R7 empty close no pulse", pkt_done, 0);
    wr(RA_SHIFT, 8'h5A);  rd(RA_SHIFT, d);  check("R2 shift data", d, 8'h5A);

    // R3 R4 R5 inbound sweep
    last_sr = 8'h5A;
    foreach (lens[li]) begin
      int n = lens[li];
      load_reply(n);
      k = (n < 128) ? n : 128;
      check("R5 ready low while pending", rpl_ready, 0);
      rd(RA_PORT, d); check("R4 request low with data", d[PB_REQ_BIT], 0);
      for (int j = 0; j < k + 2; j++) begin
        toggle(j);
        rd(RA_FLAG, d);
        check("R9 flag after move", d[FLG_SHIFT_BIT], (j < k));
        check("R10 irq with enable", irq, (j < k));
        rd(RA_SHIFT, d);
        if (j < k) last_sr = rbyte(j, n);
        check("R3 inbound byte", d, last_sr);
        rd(RA_PORT, d);
        check("R4 request line", d[PB_REQ_BIT], (j >= k - 1));
      end
      check("R5 ready after exhaustion", rpl_ready, 1);
    end

    // R11 non-handshake port change
    load_reply(2);
    pb_sh[0] = ~pb_sh[0];
    wr(RA_PORT, pb_sh);
    @(negedge clk);
    rd(RA_SHIFT, d); check("R11 no move on other bits", d, last_sr);
    rd(RA_FLAG, d);  check("R11 flag untouched", d[FLG_SHIFT_BIT], 0);
    rd(RA_PORT, d);  check("R11 request still low", d[PB_REQ_BIT], 0);

    // R10 enable gating
    wr(RA_ENABLE, 8'h04);
    toggle(1);
    rd(RA_FLAG, d); check("R9 flag set", d[FLG_SHIFT_BIT], 1);
    check("R10 irq masked", irq, 0);
    wr(RA_ENABLE, 8'h84);
    check("R10 irq unmasked", irq, 1);
    rd(RA_SHIFT, d); check("R3 byte 0 of 2", d, rbyte(0, 2));
    check("R9 read clears irq", irq, 0);
    toggle(0);
    rd(RA_SHIFT, d); check("R3 byte 1 of 2", d, rbyte(1, 2));

    // R6 R7 R8 outbound sweep
    foreach (olen[oi]) begin
      int n = olen[oi];
      wr(RA_AUX, 8'h10);
      for (int i = 0; i < n; i++) begin
        wr(RA_SHIFT, obyte(i, n));
        toggle(i);
        rd(RA_FLAG, d);
        check("R6 flag on capture", d[FLG_SHIFT_BIT], (i < 16));
        rd(RA_SHIFT, d);
        check("R6 shift data kept", d, obyte(i, n));
      end
      wr(RA_AUX, 8'h00);
      check("R7 done pulse", pkt_done, 1);
      @(negedge clk);
      check("R7 pulse one cycle", pkt_done, 0);
      drain((n < 16) ? n : 16, n);
    end

    // R7 empty close
    wr(RA_AUX, 8'h10);
    wr(RA_AUX, 8'h00);
    check("R7 no pulse when empty", pkt_done, 0);
    repeat (3) @(negedge clk);
    check("R7 no stream when empty", pkt_valid, 0);

    // R8 stalled stream, toggles dropped
    wr(RA_AUX, 8'h10);
    for (int i = 0; i < 2; i++) begin
      wr(RA_SHIFT, obyte(i, 2));
      toggle(i);
    end
    wr(RA_AUX, 8'h00);
    check("R7 done pulse stall case", pkt_done, 1);
    rd(RA_SHIFT, d);
    d = pkt_data;
    check("R8 valid while stalled", pkt_valid, 1);
    wr(RA_AUX, 8'h10);
    wr(RA_SHIFT, 8'hEE);
    toggle(0);
    rd(RA_FLAG, d); check("R8 dropped toggle no flag", d[FLG_SHIFT_BIT], 0);
    check("R8 data stable while stalled", pkt_data, obyte(0, 2));
    wr(RA_AUX, 8'h00);
    check("R8 no pulse for dropped", pkt_done, 0);
    drain(2, 2);

    summary();
  end
endmodule